// File: doc/BRIEF.md
# Zero-Anchored Two-Read Register File

This block is a small register file with eight addressable entries of four bits each. It has two independent read ports and one write port. Entry 0 has no storage behind it. It always reads as zero, and a write aimed at it is dropped. Entries 1 to 7 are flip-flops on a single shared clock.

The write strobe is meant to be a one-cycle tick from a slow pulse generator, so the datapath can step at a visible rate. The strobe acts only through the flip-flop enables, and the clock itself is never gated.

Reads are combinational. A port selecting the entry being written in the current cycle shows the stored value until the clock edge commits the new one. An active-high synchronous reset clears every stored entry.

Both ports are plain select/data pins with no handshake. A read is always available, and a write is taken on any rising edge where the strobe is high, so there is no back-pressure.

Top module: `regfile_z0`

## Requirements
- R1: The file has 8 entries addressed by 3-bit selects, each 4 bits wide. Port A returns the entry named by `rd_sel_a` and port B returns the entry named by `rd_sel_b`, with no clock edge in between and independently of each other.
- R2: When `rd_sel_a` is 0, `rd_data_a` is 4'b0000 whatever has been written.
- R3: When `rd_sel_b` is 0, `rd_data_b` is 4'b0000 whatever has been written.
- R4: On a rising edge with `wr_en` high and `wr_sel` in 1..7, the entry `wr_sel` takes `wr_data`. The new value is readable right after that edge.
- R5: A write with `wr_sel` = 0 changes no entry, and entry 0 still reads as zero afterwards.
- R6: On an edge where `wr_en` is low, no entry changes.
- R7: While a write to entry k is pending in a cycle, a port reading k returns the old contents until the edge.
- R8: A rising edge with `rst` high clears entries 1..7 to zero, whatever `wr_en` is.
- R9: A write changes only the addressed entry; the other six stored entries keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all stored entries |
| rst | input | 1 | Synchronous active-high clear |
| wr_en | input | 1 | Write strobe, one-cycle tick |
| wr_sel | input | 3 | Entry number to write |
| wr_data | input | 4 | Value to write |
| rd_sel_a | input | 3 | Entry number for read port A |
| rd_data_a | output | 4 | Contents selected on port A |
| rd_sel_b | input | 3 | Entry number for read port B |
| rd_data_b | output | 4 | Contents selected on port B |

## Verification
Two conditions are hard to produce from the ports. The first is a pending write whose target is being read in the same cycle. The second is a write to entry 0 that must leave every real entry untouched.

The stimulus first loads all seven entries with distinct non-zero values. This makes any stray write or any leak into entry 0 visible. It then holds a write to an entry with a read port aimed at it, and checks the port both before and after the edge.

A write to entry 0 with all-ones data is followed by a sweep of every entry on both ports.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int RF_ADDR_W = 3;
  localparam int RF_DATA_W = 4;
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int ADDR_W = 3,
  localparam int NREG = 1 << ADDR_W
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:1]   hit
);
  // Outputs exist only for entries 1..NREG-1; entry 0 has no enable.
  for (genvar i = 1; i < NREG; i++) begin : g_dec
    assign hit[i] = en && (addr == ADDR_W'(i));
  end
endmodule

// File: rtl/rf_cell.sv
module rf_cell #(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_r = '0;

  always_ff @(posedge clk) begin
    if (rst)     q_r <= '0;
    else if (en) q_r <= d;
  end

  assign q = q_r;
endmodule

// File: rtl/rf_rd_mux.sv
module rf_rd_mux #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 4,
  localparam int NREG = 1 << ADDR_W
) (
  input  logic [NREG-1:1][DATA_W-1:0] regs,
  input  logic [ADDR_W-1:0]           sel,
  output logic [DATA_W-1:0]           data
);
  logic [DATA_W-1:0] tbl [NREG];

  // Slot 0 is tied to ground; the other slots come from storage.
  assign tbl[0] = '0;
  for (genvar i = 1; i < NREG; i++) begin : g_slot
    assign tbl[i] = regs[i];
  end

  assign data = tbl[sel];
endmodule

// File: rtl/regfile_z0.sv
module regfile_z0 #(
  parameter int ADDR_W = rf_pkg::RF_ADDR_W,
  parameter int DATA_W = rf_pkg::RF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_sel_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_sel_b,
  output logic [DATA_W-1:0] rd_data_b
);
  localparam int NREG = 1 << ADDR_W;

  logic [NREG-1:1]             wr_hit;
  logic [NREG-1:1][DATA_W-1:0] store;

  rf_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .en  (wr_en),
    .addr(wr_sel),
    .hit (wr_hit)
  );

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    rf_cell #(.DATA_W(DATA_W)) u_cell (
      .clk(clk),
      .rst(rst),
      .en (wr_hit[i]),
      .d  (wr_data),
      .q  (store[i])
    );
  end

  rf_rd_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd_a (
    .regs(store),
    .sel (rd_sel_a),
    .data(rd_data_a)
  );

  rf_rd_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd_b (
    .regs(store),
    .sel (rd_sel_b),
    .data(rd_data_b)
  );
endmodule

// File: rtl/regfile_z0_chk.sv
module regfile_z0_chk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rd_sel_a,
  input logic [DATA_W-1:0] rd_data_a,
  input logic [ADDR_W-1:0] rd_sel_b,
  input logic [DATA_W-1:0] rd_data_b
);
  // R2
  zero_port_a_chk: assert property (@(posedge clk)
    (rd_sel_a == '0) |-> (rd_data_a == '0));

  // R3
  zero_port_b_chk: assert property (@(posedge clk)
    (rd_sel_b == '0) |-> (rd_data_b == '0));

  // R4
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel != '0) |=>
      ((rd_sel_a == $past(wr_sel)) -> (rd_data_a == $past(wr_data))));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en ##1 $stable(rd_sel_a)) |-> $stable(rd_data_a));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    ($past(rst) === 1'b1) |-> (rd_data_a == '0 && rd_data_b == '0));
endmodule

bind regfile_z0 regfile_z0_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .rd_sel_a(rd_sel_a), .rd_data_a(rd_data_a),
  .rd_sel_b(rd_sel_b), .rd_data_b(rd_data_b)
);

// File: tb/tb_regfile_z0.sv
module tb_regfile_z0;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [3:0] wr_data = '0;
  logic [2:0] rd_sel_a = '0;
  logic [2:0] rd_sel_b = '0;
  logic [3:0] rd_data_a, rd_data_b;

  logic [3:0] mdl [8];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  regfile_z0 dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel_a(rd_sel_a), .rd_data_a(rd_data_a),
    .rd_sel_b(rd_sel_b), .rd_data_b(rd_data_b)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One write cycle: drive at negedge, commit on the next posedge.
  task automatic do_write(input logic [2:0] sel, input logic [3:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    if (sel != 3'd0) mdl[sel] = data;
  endtask

  // Sweep every entry on both ports against the model.
  task automatic sweep(input string req);
    for (int i = 0; i < 8; i++) begin
      rd_sel_a = 3'(i); rd_sel_b = 3'(7 - i);
      #1;
      chk(req, rd_data_a, mdl[i]);
      chk(req, rd_data_b, mdl[7 - i]);
    end
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    sweep("R8 reset state");
  endtask

  task automatic t_fill;
    for (int i = 1; i < 8; i++) do_write(3'(i), 4'(i + 8));
    sweep("R4 fill readback");
    sweep("R1 two ports");
  endtask

  task automatic t_zero_entry;
    do_write(3'd0, 4'hF);
    rd_sel_a = 3'd0; rd_sel_b = 3'd0; #1;
    chk("R2 port A entry 0", rd_data_a, 4'h0);
    chk("R3 port B entry 0", rd_data_b, 4'h0);
    sweep("R5 write to 0 no effect");
  endtask

  task automatic t_enable_low;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 3'd4; wr_data = 4'h1;
    repeat (3) @(negedge clk);
    sweep("R6 enable low holds");
  endtask

  task automatic t_single_target;
    do_write(3'd6, 4'h3);
    sweep("R9 only target changes");
  endtask

  task automatic t_read_during_write;
    @(negedge clk);
    rd_sel_a = 3'd2; rd_sel_b = 3'd2;
    wr_en = 1'b1; wr_sel = 3'd2; wr_data = 4'h5;
    #1;
    chk("R7 old value port A", rd_data_a, mdl[2]);
    chk("R7 old value port B", rd_data_b, mdl[2]);
    @(negedge clk);
    wr_en = 1'b0; mdl[2] = 4'h5;
    #1;
    chk("R4 new value after edge", rd_data_a, 4'h5);
  endtask

  task automatic t_reset_with_write;
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b1; wr_sel = 3'd7; wr_data = 4'hA;
    @(negedge clk);
    rst = 1'b0; wr_en = 1'b0;
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    sweep("R8 reset over write");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fill();
    t_zero_entry();
    t_enable_low();
    t_single_target();
    t_read_during_write();
    t_reset_with_write();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule